// File: doc/BRIEF.md
# Programmable Delayed One-Shot Pulse Generator

This block turns a falling edge on an active-low trigger input into one output pulse. The pulse begins a programmable number of clock cycles after the trigger and stays high for a programmable number of cycles. The trigger may be far narrower than a clock period. A small capture flop, set asynchronously by the trigger edge, holds it until a synchronizer has brought it into the clock domain. The synchronized level is turned into a one-cycle start strobe.

The timing engine has three phases: idle, delay and width. It samples the delay and width inputs at the moment it accepts a trigger, so changing them later cannot disturb a pulse already under way. A busy flag is high for the whole delay and width period. While it is high, further triggers are dropped. All timing is done by counters clocked on the rising edge, so the pulse edges fall exactly on clock edges.

Top module: `delayed_oneshot`

## Requirements
- R1: A falling edge on the active-low `trig_n` starts a pulse, even when `trig_n` is low for much less than one clock period. A single falling edge gives exactly one pulse, even if `trig_n` then stays low across many clock edges.
- R2: Let k0 be the first rising clock edge after the falling edge of `trig_n`. The trigger is accepted at rising edge k0+2. When the sampled width is nonzero, `busy` goes high right after that edge.
- R3: With a sampled delay D and width W (W nonzero), `pulse_out` goes high right after the D-th rising edge following the acceptance edge. It then stays high for exactly W clock cycles.
- R4: A sampled delay of 0 makes `pulse_out` go high right after the acceptance edge itself.
- R5: A sampled width of 0 produces no pulse, and `busy` stays low.
- R6: `delay_val` and `width_val` are sampled only at the acceptance edge. Changing them afterwards has no effect on the pulse in progress.
- R7: A trigger whose acceptance edge comes while `busy` is high is ignored. This includes the last edge of the width phase. Such a trigger produces no second pulse and does not stretch the current one.
- R8: A synchronous reset (`rst` high at a rising edge) clears the capture path, the phase, the counter and the output. `pulse_out` and `busy` are low after that edge, and a trigger captured before the reset leaves no pulse behind.
- R9: `busy` stays high for exactly D+W cycles from the acceptance edge, so it falls on the same edge as `pulse_out`. Delays up to 2^DLY_W-1 and widths up to 2^WID_W-1 are supported (12 and 13 bits by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| trig_n | input | 1 | Active-low trigger; its falling edge starts a pulse |
| delay_val | input | DLY_W | Delay in clock cycles from acceptance to pulse start |
| width_val | input | WID_W | Pulse length in clock cycles; 0 suppresses the pulse |
| pulse_out | output | 1 | Registered one-shot output |
| busy | output | 1 | High during the delay and width phases |

## Verification
The assertions check a set of rules on every cycle:
- the start strobe lasts a single cycle;
- a strobe that comes while busy leaves the latched delay and width untouched;
- zero-delay and zero-width triggers move straight to the right phase;
- the counter never passes its latched limit;
- the output is high only in the width phase.

Only the bench scenarios can show the end-to-end latency from an asynchronous trigger edge to the output edges. The same holds for the exact pulse and busy lengths across random delays and widths, and for ignoring a retrigger timed onto the final busy edge. A trigger held low for many cycles giving a single pulse, and the effect of a reset in mid-pulse, are also shown only by the scenarios.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_WIDTH = 2'd2
    } phase_t;

    function automatic int max_width(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/trig_capture.sv
`timescale 1ns/1ps
module trig_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_n,
    output logic start_stb
);
    // Shift chain: SYNC_STAGES synchronizer flops plus one history flop
    localparam int CHAIN = SYNC_STAGES + 1;

    logic             cap_q;
    logic [CHAIN-1:0] chain_q;
    logic             sync_lvl;
    logic             sync_prev;

    assign sync_lvl  = chain_q[SYNC_STAGES-1];
    assign sync_prev = chain_q[SYNC_STAGES];
    assign start_stb = sync_lvl & ~sync_prev;

    // Capture flop: set asynchronously by the trigger's falling edge,
    // cleared once the synchronized level has seen it
    always_ff @(posedge clk or negedge trig_n) begin
        if (!trig_n)
            cap_q <= 1'b1;
        else if (rst || sync_lvl)
            cap_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else
            chain_q <= {chain_q[CHAIN-2:0], cap_q};
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        start_stb |=> !start_stb); // R1

endmodule

// File: rtl/oneshot_timer.sv
`timescale 1ns/1ps
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int DLY_W = 12,
    parameter int WID_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_stb,
    input  logic [DLY_W-1:0] delay_val,
    input  logic [WID_W-1:0] width_val,
    output logic             pulse_out,
    output logic             busy
);
    localparam int CNT_W = max_width(DLY_W, WID_W);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DLY_W-1:0] lat_dly_q;
    logic [WID_W-1:0] lat_wid_q;
    logic             pulse_q;
    logic [CNT_W-1:0] dly_ext;
    logic [CNT_W-1:0] wid_ext;
    logic             dly_last;
    logic             wid_last;

    assign dly_ext  = CNT_W'(lat_dly_q);
    assign wid_ext  = CNT_W'(lat_wid_q);
    assign dly_last = (cnt_q == dly_ext - CNT_W'(1));
    assign wid_last = (cnt_q == wid_ext - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            lat_dly_q <= '0;
            lat_wid_q <= '0;
            pulse_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_stb && (width_val != '0)) begin
                        lat_dly_q <= delay_val;
                        lat_wid_q <= width_val;
                        cnt_q     <= '0;
                        if (delay_val == '0) begin
                            phase_q <= PH_WIDTH;
                            pulse_q <= 1'b1;
                        end else begin
                            phase_q <= PH_DELAY;
                        end
                    end
                end
                PH_DELAY: begin
                    if (dly_last) begin
                        cnt_q   <= '0;
                        phase_q <= PH_WIDTH;
                        pulse_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_WIDTH: begin
                    if (wid_last) begin
                        cnt_q   <= '0;
                        phase_q <= PH_IDLE;
                        pulse_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign pulse_out = pulse_q;
    assign busy      = (phase_q != PH_IDLE);

    AST_PULSE_IN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (phase_q == PH_WIDTH)); // R3
    AST_DELAY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (start_stb && phase_q == PH_IDLE && width_val != '0 && delay_val == '0)
        |=> pulse_q); // R4
    AST_WIDTH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (start_stb && phase_q == PH_IDLE && width_val == '0)
        |=> (phase_q == PH_IDLE)); // R5
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (start_stb && phase_q != PH_IDLE)
        |=> ($stable(lat_dly_q) && $stable(lat_wid_q))); // R7
    AST_DLY_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DELAY) |-> (cnt_q < dly_ext)); // R9
    AST_WID_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WIDTH) |-> (cnt_q < wid_ext)); // R9

endmodule

// File: rtl/delayed_oneshot.sv
`timescale 1ns/1ps
module delayed_oneshot #(
    parameter int DLY_W       = 12,
    parameter int WID_W       = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_n,
    input  logic [DLY_W-1:0] delay_val,
    input  logic [WID_W-1:0] width_val,
    output logic             pulse_out,
    output logic             busy
);
    logic start_stb;

    trig_capture #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .trig_n    (trig_n),
        .start_stb (start_stb)
    );

    oneshot_timer #(
        .DLY_W(DLY_W),
        .WID_W(WID_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_stb (start_stb),
        .delay_val (delay_val),
        .width_val (width_val),
        .pulse_out (pulse_out),
        .busy      (busy)
    );

endmodule

// File: tb/delayed_oneshot_tb_top.sv
`timescale 1ns/1ps
module delayed_oneshot_tb_top;
    localparam int DLY_W = 12;
    localparam int WID_W = 13;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig_n = 1'b1;
    logic [DLY_W-1:0] delay_val = '0;
    logic [WID_W-1:0] width_val = '0;
    logic             pulse_out;
    logic             busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    delayed_oneshot #(.DLY_W(DLY_W), .WID_W(WID_W)) dut_i (
        .clk(clk), .rst(rst), .trig_n(trig_n),
        .delay_val(delay_val), .width_val(width_val),
        .pulse_out(pulse_out), .busy(busy)
    );

    // m = negedge count after the one preceding the trigger's falling edge
    function automatic bit exp_pulse(int m, int d, int w);
        return (w != 0) && (m >= 3 + d) && (m < 3 + d + w);
    endfunction
    function automatic bit exp_busy(int m, int d, int w);
        return (w != 0) && (m >= 3) && (m < 3 + d + w);
    endfunction

    task automatic chk(bit act, bit exp, string tag, int m);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, m, act, exp);
        end
    endtask

    task automatic run_profile(int d, int w, int retrig_m, int hold_m, int chg_m, string tag);
        delay_val = DLY_W'(d);
        width_val = WID_W'(w);
        @(negedge clk);
        #0.5 trig_n = 1'b0;
        if (hold_m == 0) begin
            #1 trig_n = 1'b1;
        end
        for (int m = 1; m <= d + w + 6; m++) begin
            @(negedge clk);
            if (m == hold_m) trig_n = 1'b1;
            chk(pulse_out, exp_pulse(m, d, w), {tag, " pulse"}, m);
            chk(busy, exp_busy(m, d, w), {tag, " busy"}, m);
            if (m == chg_m) begin
                delay_val = DLY_W'($urandom);
                width_val = WID_W'($urandom);
            end
            if (m == retrig_m) begin
                #0.5 trig_n = 1'b0;
                #1 trig_n = 1'b1;
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(pulse_out, 1'b0, "R8 reset pulse", 0);
        chk(busy, 1'b0, "R8 reset busy", 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Directed corner cases
        run_profile(0, 1, -1, 0, -1, "R4 zero delay");
        run_profile(3, 0, -1, 0, -1, "R5 zero width");
        run_profile(0, 0, -1, 0, -1, "R5 zero both");
        run_profile(10, 4700, -1, 0, 50, "R3 R6 long width");
        run_profile(4095, 3, -1, 0, -1, "R9 max delay");
        run_profile(2, 5, -1, 12, -1, "R1 held low");
        run_profile(4, 6, 10, 0, -1, "R7 retrig last busy edge");
        run_profile(1, 8, 5, 0, -1, "R7 retrig in width");
        run_profile(6, 2, 3, 0, -1, "R7 retrig in delay");

        // Reset in mid-pulse clears everything
        delay_val = DLY_W'(2);
        width_val = WID_W'(20);
        @(negedge clk);
        #0.5 trig_n = 1'b0;
        #1 trig_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(pulse_out, 1'b1, "R3 before reset", 8);
        rst = 1'b1;
        @(negedge clk);
        chk(pulse_out, 1'b0, "R8 mid reset pulse", 9);
        chk(busy, 1'b0, "R8 mid reset busy", 9);
        rst = 1'b0;
        for (int m = 0; m < 30; m++) begin
            @(negedge clk);
            chk(pulse_out, 1'b0, "R8 after reset pulse", m);
            chk(busy, 1'b0, "R8 after reset busy", m);
        end

        // Reset right after a capture: no pulse survives
        @(negedge clk);
        #0.5 trig_n = 1'b0;
        #1 trig_n = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < 30; m++) begin
            @(negedge clk);
            chk(pulse_out, 1'b0, "R8 captured then reset", m);
        end

        // Random trials
        for (int t = 0; t < 40; t++) begin
            int d;
            int w;
            int rm;
            d  = $urandom_range(0, 30);
            w  = $urandom_range(0, 30);
            rm = ((t % 3 == 0) && (w >= 1) && (d + w >= 2)) ? d + w : -1;
            run_profile(d, w, rm, 0, 4, "R2 R3 R6 R7 R9 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule